// File: doc/BRIEF.md
# Multi-Mode Pixel Color Processor

This block sits between a video-memory fetch engine and a display timing stage. It accepts 32-bit words from video memory through a valid/ready handshake and unpacks them into a stream of 24-bit RGB pixels, one pixel per clock while data is available. The pixel format is set by a mode input. Two formats need no table: 32-bit and 24-bit true color. Two more widen their data: 16-bit 5:6:5 color and 8-bit gray. In 8-bit palette mode, each byte indexes an on-chip color table.

The color table has two banks. Software writes either bank at any time through a dedicated write port. A request to change the bank used for display is held until the next vertical-retrace strobe, so the palette never changes in the middle of a frame. The table read takes one clock. Every other format passes through a matching register, so a pixel appears one clock after its bytes reach the head of the unpacking buffer in every mode.

Top module: `pix_color_proc`

## Requirements
- R1: After reset `pix_valid` is 0, `in_ready` is 1, the mode register holds code 0 and display bank 0 is selected.
- R2: Mode code 0 (32-bit color): each accepted word gives one pixel equal to word bits 23:0. Bits 31:24 have no effect on the output.
- R3: Mode code 1 (24-bit packed): the word stream is read as a byte stream, lowest byte of each word first. Each pixel is three consecutive bytes, with the first byte placed in output bits 7:0 and the third in bits 23:16. Three words therefore give four pixels.
- R4: Mode code 2 (16-bit 5:6:5): each word gives two pixels, bits 15:0 first. A pixel p gives red p[15:11], green p[10:5] and blue p[4:0]. Each channel is widened to 8 bits by copying its most significant bits into the freed low bits.
- R5: Mode code 3 (8-bit gray): each word gives four pixels, byte 0 first. Each byte is copied onto all three output channels.
- R6: Mode code 4 (8-bit palette): each word gives four indices, byte 0 first. Each pixel is the 24-bit entry at that index in the current display bank. Codes 5 to 7 behave as code 0.
- R7: A table write (`tbl_we`, `tbl_bank`, `tbl_addr`, `tbl_data`) to either bank takes effect at the clock edge. Any pixel looked up after that edge returns the new entry.
- R8: A pulse on `bank_req` latches `bank_req_sel` as a pending bank. The display bank changes only on a `vretrace` pulse while a request is pending. A later request replaces an earlier one. A retrace with nothing pending leaves the bank unchanged.
- R9: With the buffer empty, a word accepted at clock edge E produces `pix_valid` high in the cycle after edge E+1. This latency is the same in every mode.
- R10: With words offered on every cycle, the block emits one pixel on every clock in every mode, with no gaps.
- R11: A change of the mode input discards all buffered bytes. No pixel is ever built from bytes accepted under the previous mode.
- R12: `in_ready` does not depend on `in_valid`. A word held while `in_ready` is low is accepted later without loss or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Pixel format code (see R2 to R6) |
| in_word | input | 32 | Word fetched from video memory |
| in_valid | input | 1 | `in_word` is offered |
| in_ready | output | 1 | Word accepted at the next edge if offered |
| tbl_we | input | 1 | Color table write strobe |
| tbl_bank | input | 1 | Bank written |
| tbl_addr | input | 8 | Entry written |
| tbl_data | input | 24 | RGB value written |
| bank_req | input | 1 | Request a display-bank change |
| bank_req_sel | input | 1 | Bank requested |
| vretrace | input | 1 | Vertical-retrace strobe |
| pix_rgb | output | 24 | Pixel, red in 23:16, blue in 7:0 |
| pix_valid | output | 1 | `pix_rgb` holds a pixel this cycle |

## Verification
The bench builds the block with its default 8-bit index, so both 256-entry table banks are written in full, and every index is read back through the palette path under both banks. At this size all 65536 5:6:5 codes can be streamed in the 16-bit mode, and all 256 gray levels in the 8-bit gray mode. Long runs in the 24-bit mode drive the unpacker's stall and carry-over patterns, and the bench checks that no gaps appear in the output.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

  typedef enum logic [2:0] {
    CM_RGB32 = 3'd0,
    CM_RGB24 = 3'd1,
    CM_RGB16 = 3'd2,
    CM_GRAY8 = 3'd3,
    CM_PAL8  = 3'd4
  } cmode_e;

  // bytes consumed from the unpack buffer for one pixel
  function automatic logic [3:0] bytes_per_pix(input logic [2:0] m);
    case (m)
      CM_RGB24:          return 4'd3;
      CM_RGB16:          return 4'd2;
      CM_GRAY8, CM_PAL8: return 4'd1;
      default:           return 4'd4;
    endcase
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  // direct (non-table) color from the bytes at the buffer head
  function automatic logic [23:0] expand_pix(input logic [2:0] m, input logic [31:0] raw);
    case (m)
      CM_RGB16: return {widen5(raw[15:11]), widen6(raw[10:5]), widen5(raw[4:0])};
      CM_GRAY8: return {raw[7:0], raw[7:0], raw[7:0]};
      CM_PAL8:  return 24'd0;
      default:  return raw[23:0];
    endcase
  endfunction

endpackage

// File: rtl/pcp_unpack.sv
module pcp_unpack
  import pcp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              pop,
  output logic [WORD_W-1:0] pop_raw,
  output logic [2:0]        pop_mode
);
  localparam int WB    = WORD_W / 8;
  localparam int BUF_B = 2 * WB;
  localparam int BUF_W = 8 * BUF_B;
  localparam int CNT_W = $clog2(BUF_B + 1);

  logic [BUF_W-1:0] buf_q;
  logic [CNT_W-1:0] fill_q;
  logic [2:0]       mode_q;

  logic             mode_chg;
  logic             push;
  logic [CNT_W-1:0] need, take, rem;
  logic [BUF_W-1:0] shifted, merged;

  assign mode_chg = (mode != mode_q);
  assign need     = CNT_W'(bytes_per_pix(mode_q));
  assign pop      = !mode_chg && (fill_q >= need);
  assign take     = pop ? need : '0;
  assign rem      = fill_q - take;
  assign in_ready = !mode_chg && (rem <= CNT_W'(WB));
  assign push     = in_valid && in_ready;
  assign shifted  = buf_q >> {take, 3'b000};
  assign merged   = shifted | (BUF_W'(in_word) << {rem, 3'b000});
  assign pop_raw  = buf_q[WORD_W-1:0];
  assign pop_mode = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      fill_q <= '0;
      mode_q <= CM_RGB32;
    end else begin
      mode_q <= mode;
      if (mode_chg) begin
        buf_q  <= '0;
        fill_q <= '0;
      end else begin
        buf_q  <= push ? merged : shifted;
        fill_q <= rem + (push ? CNT_W'(WB) : '0);
      end
    end
  end

  // R11: a mode change leaves nothing buffered
  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (fill_q == '0));

  // R12: the buffer never holds more than its capacity
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(BUF_B));

  // R12: a word offered while not ready stays pending and leaves the buffer untouched apart from pops
  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !mode_chg) |=> (fill_q == $past(rem)));

endmodule

// File: rtl/pcp_bank_ctl.sv
module pcp_bank_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic req_sel,
  input  logic retrace,
  output logic active
);
  logic pend_q, pend_sel_q;
  logic apply;

  assign apply = retrace && pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_sel_q <= 1'b0;
      active     <= 1'b0;
    end else begin
      if (apply) active <= pend_sel_q;
      if (req) begin
        pend_q     <= 1'b1;
        pend_sel_q <= req_sel;
      end else if (retrace) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R8: the display bank only moves on a retrace
  p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !retrace |=> $stable(active));

  // R8: a retrace with a pending request installs the requested bank
  p_bank_apply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (active == $past(pend_sel_q)));

endmodule

// File: rtl/pcp_clut.sv
module pcp_clut #(
  parameter int IDX_W = 8,
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             we,
  input  logic             wbank,
  input  logic [IDX_W-1:0] waddr,
  input  logic [RGB_W-1:0] wdata,
  input  logic             rd_en,
  input  logic             rd_bank,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [RGB_W-1:0] rd_data
);
  localparam int DEPTH = 2 << IDX_W;

  logic [RGB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{wbank, waddr}] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[{rd_bank, rd_idx}];
  end

endmodule

// File: rtl/pix_color_proc.sv
module pix_color_proc
  import pcp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic [31:0]      in_word,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             tbl_we,
  input  logic             tbl_bank,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [23:0]      tbl_data,
  input  logic             bank_req,
  input  logic             bank_req_sel,
  input  logic             vretrace,
  output logic [23:0]      pix_rgb,
  output logic             pix_valid
);
  localparam int WORD_W = 32;
  localparam int RGB_W  = 24;

  logic              pop;
  logic [WORD_W-1:0] pop_raw;
  logic [2:0]        pop_mode;
  logic              disp_bank;
  logic              lut_rd;
  logic [RGB_W-1:0]  lut_q;

  logic              s1_valid;
  logic              s1_pal;
  logic [2:0]        s1_mode;
  logic [RGB_W-1:0]  s1_rgb;

  pcp_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .in_word  (in_word),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .pop      (pop),
    .pop_raw  (pop_raw),
    .pop_mode (pop_mode)
  );

  pcp_bank_ctl u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (bank_req),
    .req_sel (bank_req_sel),
    .retrace (vretrace),
    .active  (disp_bank)
  );

  assign lut_rd = pop && (pop_mode == CM_PAL8);

  pcp_clut #(.IDX_W(IDX_W), .RGB_W(RGB_W)) u_clut (
    .clk     (clk),
    .we      (tbl_we),
    .wbank   (tbl_bank),
    .waddr   (tbl_addr),
    .wdata   (tbl_data),
    .rd_en   (lut_rd),
    .rd_bank (disp_bank),
    .rd_idx  (pop_raw[IDX_W-1:0]),
    .rd_data (lut_q)
  );

  // delay register for the direct formats, matching the table read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_pal   <= 1'b0;
      s1_mode  <= CM_RGB32;
      s1_rgb   <= '0;
    end else begin
      s1_valid <= pop;
      if (pop) begin
        s1_pal  <= (pop_mode == CM_PAL8);
        s1_mode <= pop_mode;
        s1_rgb  <= expand_pix(pop_mode, pop_raw);
      end
    end
  end

  assign pix_valid = s1_valid;
  assign pix_rgb   = s1_pal ? lut_q : s1_rgb;

  // R9: a pixel leaves exactly one clock after it is taken from the buffer
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> pix_valid);
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pop |=> !pix_valid);

  // R5: gray pixels carry one value on all three channels
  p_gray_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && s1_mode == CM_GRAY8) |->
      (pix_rgb[23:16] == pix_rgb[7:0] && pix_rgb[15:8] == pix_rgb[7:0]));

  // R4: widened low bits repeat the channel's top bits
  p_widen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && s1_mode == CM_RGB16) |->
      (pix_rgb[18:16] == pix_rgb[23:21] && pix_rgb[9:8] == pix_rgb[15:14] &&
       pix_rgb[2:0] == pix_rgb[7:5]));

endmodule

// File: tb/sim_pix_color_proc.sv
module sim_pix_color_proc;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  logic [2:0]  mode = 3'd0;
  logic [31:0] in_word = '0;
  logic        in_valid = 1'b0;
  logic        tbl_we = 1'b0, tbl_bank = 1'b0;
  logic [7:0]  tbl_addr = '0;
  logic [23:0] tbl_data = '0;
  logic        bank_req = 1'b0, bank_req_sel = 1'b0, vretrace = 1'b0;
  wire         in_ready;
  wire  [23:0] pix_rgb;
  wire         pix_valid;

  pix_color_proc u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_word(in_word), .in_valid(in_valid),
    .in_ready(in_ready), .tbl_we(tbl_we), .tbl_bank(tbl_bank), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .bank_req(bank_req), .bank_req_sel(bank_req_sel),
    .vretrace(vretrace), .pix_rgb(pix_rgb), .pix_valid(pix_valid)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] wbuf [0:32767];
  logic [23:0] expv [0:65535];
  int exp_n = 0, mon_i = 0, bad_at = 0;
  bit mon_en = 0, mon_bad = 0;
  logic [23:0] bad_act = '0, bad_exp = '0;
  int cyc = 0, first_c = 0, last_c = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_en && pix_valid) begin
      if (mon_i == 0) first_c = cyc;
      last_c = cyc;
      if (mon_i >= exp_n) begin
        if (!mon_bad) begin mon_bad = 1; bad_act = pix_rgb; bad_exp = 'x; bad_at = mon_i; end
      end else if (pix_rgb !== expv[mon_i]) begin
        if (!mon_bad) begin mon_bad = 1; bad_act = pix_rgb; bad_exp = expv[mon_i]; bad_at = mon_i; end
      end
      mon_i++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expct);
    checks++;
    if (act !== expct) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expct);
    end
  endtask

  function automatic logic [23:0] pal0(input int i);
    logic [7:0] b = 8'(i);
    return {b, ~b, b ^ 8'hA5};
  endfunction

  function automatic logic [23:0] pal1(input int i);
    logic [7:0] b = 8'(i);
    return {b ^ 8'h3C, b, ~b};
  endfunction

  function automatic logic [7:0] byte_at(input int j);
    return 8'(wbuf[j / 4] >> (8 * (j % 4)));
  endfunction

  function automatic logic [23:0] rgb565(input int p);
    int r, g, b;
    r = (p / 2048) % 32; g = (p / 32) % 64; b = p % 32;
    return {8'(r * 8 + r / 4), 8'(g * 4 + g / 16), 8'(b * 8 + b / 4)};
  endfunction

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk); mode = m;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input int n);
    int i = 0;
    while (i < n) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = wbuf[i];
      if (in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic mon_start();
    mon_i = 0; mon_bad = 0;
    mon_en = 1;
  endtask

  task automatic mon_finish(input string tag, input bit thr);
    repeat (12) @(negedge clk);
    mon_en = 0;
    chk({tag, " pixel count"}, mon_i, exp_n);
    if (mon_bad) $display("  (first mismatch at pixel %0d)", bad_at);
    chk({tag, " pixel values"}, mon_bad ? 32'(bad_act) : 32'd0, mon_bad ? 32'(bad_exp) : 32'd0);
    if (thr) chk({tag, " R10 one pixel per clock"}, last_c - first_c, exp_n - 1);
  endtask

  task automatic run_case(input string tag, input logic [2:0] m, input int nw, input bit thr);
    set_mode(m);
    mon_start();
    send(nw);
    mon_finish(tag, thr);
  endtask

  task automatic tbl_write(input bit bank, input int addr, input logic [23:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_bank = bank; tbl_addr = 8'(addr); tbl_data = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic req_bank(input bit s);
    @(negedge clk); bank_req = 1'b1; bank_req_sel = s;
    @(negedge clk); bank_req = 1'b0;
  endtask

  task automatic retrace();
    @(negedge clk); vretrace = 1'b1;
    @(negedge clk); vretrace = 1'b0;
  endtask

  task automatic latency(input logic [2:0] m);
    set_mode(m);
    @(negedge clk);
    in_word = 32'h0403_0201; in_valid = 1'b1;
    chk("R9 ready with empty buffer", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 no pixel one clock after accept", pix_valid, 0);
    @(negedge clk);
    chk("R9 pixel two clocks after accept", pix_valid, 1);
    repeat (6) @(negedge clk);
  endtask

  task automatic build_bytes();
    for (int i = 0; i < 64; i++)
      wbuf[i] = {8'(4 * i + 3), 8'(4 * i + 2), 8'(4 * i + 1), 8'(4 * i)};
  endtask

  task automatic build_pal(input bit bank);
    build_bytes();
    exp_n = 256;
    for (int k = 0; k < 256; k++) expv[k] = bank ? pal1(k) : pal0(k);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pix_valid after reset", pix_valid, 0);
    chk("R1 in_ready after reset", in_ready, 1);

    // load both banks completely (R7)
    for (int i = 0; i < 256; i++) tbl_write(1'b0, i, pal0(i));
    for (int i = 0; i < 256; i++) tbl_write(1'b1, i, pal1(i));

    for (int m = 0; m < 5; m++) latency(3'(m));

    // R2: top byte varies and must be ignored
    for (int i = 0; i < 300; i++) begin
      wbuf[i] = (32'(i) * 32'h9E37_79B1) ^ 32'h5A00_0000;
      expv[i] = wbuf[i][23:0];
    end
    exp_n = 300;
    run_case("R2 32-bit", 3'd0, 300, 1);

    // codes 5..7 behave as 32-bit (R6)
    run_case("R6 code 6 as 32-bit", 3'd6, 300, 1);

    // R3: 24-bit packed, byte stream lowest byte first, stalls on input (R12)
    for (int i = 0; i < 300; i++) wbuf[i] = 32'(i) * 32'h01F3_A7C5 + 32'h1357;
    exp_n = 400;
    for (int k = 0; k < 400; k++) expv[k] = {byte_at(3 * k + 2), byte_at(3 * k + 1), byte_at(3 * k)};
    run_case("R3 R12 24-bit", 3'd1, 300, 1);

    // R4: every 5:6:5 code
    for (int i = 0; i < 32768; i++) wbuf[i] = {16'(2 * i + 1), 16'(2 * i)};
    exp_n = 65536;
    for (int k = 0; k < 65536; k++) expv[k] = rgb565(k);
    run_case("R4 16-bit", 3'd2, 32768, 1);

    // R5: every gray level
    build_bytes();
    exp_n = 256;
    for (int k = 0; k < 256; k++) expv[k] = {3{8'(k)}};
    run_case("R5 gray", 3'd3, 64, 1);

    // R6 / R1: palette through bank 0, the reset bank
    build_pal(1'b0);
    run_case("R6 R1 palette bank0", 3'd4, 64, 1);

    // R8: a request without retrace changes nothing
    req_bank(1'b1);
    build_pal(1'b0);
    run_case("R8 request without retrace", 3'd4, 64, 1);
    retrace();
    build_pal(1'b1);
    run_case("R8 retrace applies bank1", 3'd4, 64, 1);
    retrace();
    build_pal(1'b1);
    run_case("R8 retrace with nothing pending", 3'd4, 64, 1);
    req_bank(1'b1);
    req_bank(1'b0);
    retrace();
    build_pal(1'b0);
    run_case("R8 later request wins", 3'd4, 64, 1);

    // R7: rewrite an entry in both banks, read from each
    tbl_write(1'b0, 7, 24'h12_3456);
    tbl_write(1'b1, 7, 24'h65_4321);
    wbuf[0] = 32'h0707_0707;
    exp_n = 4;
    for (int k = 0; k < 4; k++) expv[k] = 24'h12_3456;
    run_case("R7 rewrite active bank", 3'd4, 1, 1);
    req_bank(1'b1);
    retrace();
    for (int k = 0; k < 4; k++) expv[k] = 24'h65_4321;
    run_case("R7 rewrite other bank", 3'd4, 1, 1);

    // R11: leftover byte from 24-bit mode must not join a 32-bit word
    set_mode(3'd1);
    exp_n = 2;
    expv[0] = 24'hBB_CCDD;
    expv[1] = 24'h33_2211;
    mon_start();
    wbuf[0] = 32'hAABB_CCDD;
    send(1);
    repeat (3) @(negedge clk);
    set_mode(3'd0);
    wbuf[0] = 32'h4433_2211;
    send(1);
    mon_finish("R11 mode change flush", 0);

    done = 1;
    summary();
    $finish;
  end

endmodule